// File: doc/BRIEF.md
# Two-Channel Prescaled Interval Timer

This block is a register-mapped timer with two independent 16-bit channels. Each channel divides the functional clock by a power of two that software selects, counts up at that slower rate and flags an expiry when the count reaches a programmed reload value. A channel either stops by itself after one expiry or restarts from zero and keeps producing periodic events. A level interrupt per channel follows the expiry flag when the channel's interrupt enable is set.

Software reaches the block through a simple single-cycle register port: a valid strobe, a write select, a byte address and 16-bit write data. Read data comes back in the same cycle as the request. Each channel has four registers: control, expiry status, reload value and live count. Software stops a channel by clearing its enable bit. It can then write a new reload value and set the enable bit again.

Top module: `interval_timer`

## Requirements
- R1: The register bank of channel n (n = 0, 1) starts at byte address 0x80·(n+1). Control is at bank+0x00, status at bank+0x04, reload at bank+0x08 and count at bank+0x0C. A read (bus_valid=1, bus_write=0) returns the register in the same cycle.
- R2: Control layout: bit 8 enables the interrupt, bit 5 enables counting, bit 4 selects one-shot (1) or auto-reload (0), and bits [3:0] hold the prescale code. All other control bits read as zero.
- R3: Prescale code k divides the functional clock by 2^k for k = 0..8. Codes 9 to 15 divide by 256.
- R4: When a control write changes the enable bit from 0 to 1, the prescaler and the count restart from zero. The count then rises by one on each prescaled tick, and the first expiry falls exactly (reload+1)·2^k clock cycles after that write.
- R5: Status bit 0 is set on the cycle of an expiry. Writing 1 to bit 0 clears it. An expiry in the same cycle as a clear wins and leaves the bit set. Other status bits read zero.
- R6: In one-shot mode an expiry clears the enable bit in hardware, and the count holds at the reload value.
- R7: In auto-reload mode an expiry returns the count to zero and counting continues, giving one expiry every (reload+1)·2^k cycles.
- R8: A channel's irq output is 1 exactly when its status bit and its interrupt-enable bit are both set. Status is set on expiry even when the interrupt is disabled.
- R9: While the enable bit is clear, the count and the prescaler hold their values. The count register is read-only, so writes to it are ignored.
- R10: Reads of unmapped addresses return zero, and writes to them change nothing. bus_rdata is zero when no read is requested.
- R11: After reset every register reads zero and both irq outputs are low.
- R12: The two channels run independently, each with its own mode, prescale code and reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the request cycle |
| irq | output | 2 | Per-channel level interrupt |

## Verification
An expiry and a software write can land on the same clock edge. The key case is a write-one-to-clear of the status bit in the cycle where the count reaches the reload value. The bench's reference model predicts, one half-cycle ahead, the edge on which channel 0 will expire. It then presents the status clear exactly for that edge, and judges the result by the rule that the expiry is kept. A control write that lands on the expiry edge of a running channel is checked against the same model, as are the irq outputs every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_STAT   = 'h04;
  localparam int OFS_RELOAD = 'h08;
  localparam int OFS_COUNT  = 'h0C;
  localparam int BANK_SHIFT = 7;

  localparam int BIT_IE  = 8;
  localparam int BIT_EN  = 5;
  localparam int BIT_OS  = 4;
  localparam int PRE_W   = 4;

  typedef struct packed {
    logic             ie;
    logic             en;
    logic             one_shot;
    logic [PRE_W-1:0] code;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = PRE_MAX;

  logic [PRE_W-1:0] eff_code;
  logic [DIV_W:0]   one_hot;
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] div_q, div_d;
  logic             at_limit;
  logic             div_en;

  // codes past the top divider saturate
  assign eff_code = (code > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : code;
  assign one_hot  = (DIV_W+1)'(1) << eff_code;
  assign limit    = DIV_W'(one_hot - 1'b1);
  assign at_limit = (div_q == limit);
  assign tick     = run && at_limit;
  assign div_en   = run || restart;

  always_comb begin
    div_d = div_q;
    if (restart)       div_d = '0;
    else if (at_limit) div_d = '0;
    else               div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int PRE_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              wr_reload,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  reload,
  output logic              stat,
  output logic              en,
  output logic              ie,
  output logic              one_shot,
  output logic              irq
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             stat_q, stat_d;
  logic             start, tick, expire;

  assign start  = wr_ctrl && wdata[BIT_EN] && !ctrl_q.en;
  assign expire = tick && (count_q == reload_q);

  tmr_prescaler #(.PRE_MAX(PRE_MAX)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.en),
    .restart (start),
    .code    (ctrl_q.code),
    .tick    (tick)
  );

  always_comb begin
    ctrl_d   = ctrl_q;
    count_d  = count_q;
    stat_d   = stat_q;
    reload_d = reload_q;
    if (tick) begin
      if (expire) begin
        stat_d = 1'b1;
        if (ctrl_q.one_shot) ctrl_d.en = 1'b0;
        else                 count_d   = '0;
      end else begin
        count_d = count_q + 1'b1;
      end
    end
    if (wr_stat && wdata[0] && !expire) stat_d = 1'b0;
    if (wr_reload) reload_d = wdata[CNT_W-1:0];
    if (wr_ctrl) begin
      ctrl_d.ie       = wdata[BIT_IE];
      ctrl_d.en       = wdata[BIT_EN];
      ctrl_d.one_shot = wdata[BIT_OS];
      ctrl_d.code     = wdata[PRE_W-1:0];
      if (start) count_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      count_q  <= '0;
      reload_q <= '0;
      stat_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      count_q  <= count_d;
      reload_q <= reload_d;
      stat_q   <= stat_d;
    end
  end

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[BIT_IE]      = ctrl_q.ie;
    ctrl_rd[BIT_EN]      = ctrl_q.en;
    ctrl_rd[BIT_OS]      = ctrl_q.one_shot;
    ctrl_rd[PRE_W-1:0]   = ctrl_q.code;
  end

  assign count    = count_q;
  assign reload   = reload_q;
  assign stat     = stat_q;
  assign en       = ctrl_q.en;
  assign ie       = ctrl_q.ie;
  assign one_shot = ctrl_q.one_shot;
  assign irq      = stat_q && ctrl_q.ie;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 10,
  parameter int PRE_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int BANK_W = ADDR_W - BANK_SHIFT;

  logic [BANK_W-1:0]     bank;
  logic [BANK_SHIFT-1:0] offset;
  logic                  wr_any, rd_any;

  logic [NUM_CH-1:0][DATA_W-1:0] ch_ctrl;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_count;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_reload;
  logic [NUM_CH-1:0]             ch_stat, ch_en, ch_ie, ch_os;

  assign bank   = bus_addr[ADDR_W-1:BANK_SHIFT];
  assign offset = bus_addr[BANK_SHIFT-1:0];
  assign wr_any = bus_valid && bus_write;
  assign rd_any = bus_valid && !bus_write;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (bank == BANK_W'(c + 1));

    tmr_channel #(
      .CNT_W   (CNT_W),
      .DATA_W  (DATA_W),
      .PRE_MAX (PRE_MAX)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_any && hit && (offset == BANK_SHIFT'(OFS_CTRL))),
      .wr_stat   (wr_any && hit && (offset == BANK_SHIFT'(OFS_STAT))),
      .wr_reload (wr_any && hit && (offset == BANK_SHIFT'(OFS_RELOAD))),
      .wdata     (bus_wdata),
      .ctrl_rd   (ch_ctrl[c]),
      .count     (ch_count[c]),
      .reload    (ch_reload[c]),
      .stat      (ch_stat[c]),
      .en        (ch_en[c]),
      .ie        (ch_ie[c]),
      .one_shot  (ch_os[c]),
      .irq       (irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (bank == BANK_W'(c + 1)) begin
          case (offset)
            BANK_SHIFT'(OFS_CTRL):   bus_rdata = ch_ctrl[c];
            BANK_SHIFT'(OFS_STAT):   bus_rdata = DATA_W'(ch_stat[c]);
            BANK_SHIFT'(OFS_RELOAD): bus_rdata = DATA_W'(ch_reload[c]);
            BANK_SHIFT'(OFS_COUNT):  bus_rdata = DATA_W'(ch_count[c]);
            default:                 bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_valid,
  input logic                            bus_write,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [DATA_W-1:0]               bus_rdata,
  input logic [NUM_CH-1:0]               irq,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_count,
  input logic [NUM_CH-1:0]               ch_stat,
  input logic [NUM_CH-1:0]               ch_en,
  input logic [NUM_CH-1:0]               ch_ie,
  input logic [NUM_CH-1:0]               ch_os
);
  logic [ADDR_W-8:0] a_bank;
  logic [6:0]        a_off;
  logic              a_mapped;

  assign a_bank   = bus_addr[ADDR_W-1:7];
  assign a_off    = bus_addr[6:0];
  assign a_mapped = (a_bank >= 1) && (int'(a_bank) <= NUM_CH) &&
                    (a_off[1:0] == 2'b00) && (a_off[6:4] == 3'b000);

  // R10: unmapped reads and idle cycles return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_mapped || !bus_valid || bus_write) |-> (bus_rdata == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4: count moves only by one step or back to zero
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_count[c]) |->
        ((ch_count[c] == CNT_W'($past(ch_count[c]) + 1'b1)) || (ch_count[c] == '0)));

    // R5: status only falls after a bus write
    assert_stat_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_stat[c]) |-> $past(bus_valid && bus_write));

    // R5: status only rises while the channel was running
    assert_stat_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_stat[c]) |-> $past(ch_en[c]));

    // R6: one-shot expiry stops the channel
    assert_oneshot_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_stat[c]) && ch_os[c] && !$past(bus_valid && bus_write)) |-> !ch_en[c]);

    // R8: interrupt needs both status and enable
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> (ch_stat[c] && ch_ie[c]));
  end
endmodule

bind interval_timer tmr_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ch_count  (ch_count),
  .ch_stat   (ch_stat),
  .ch_en     (ch_en),
  .ch_ie     (ch_ie),
  .ch_os     (ch_os)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  interval_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // behavioural reference state
  int m_ie[NCH], m_en[NCH], m_os[NCH], m_pre[NCH];
  int m_rel[NCH], m_cnt[NCH], m_div[NCH], m_st[NCH];

  function automatic int lim_of(int c);
    int e;
    e = (m_pre[c] > 8) ? 8 : m_pre[c];
    return (1 << e) - 1;
  endfunction

  function automatic bit will_expire(int c);
    return m_en[c] != 0 && m_div[c] == lim_of(c) && m_cnt[c] == m_rel[c];
  endfunction

  function automatic int model_read(int a);
    int bank, off, c;
    bank = a >> 7;
    off  = a & 127;
    if (bank < 1 || bank > NCH) return 0;
    c = bank - 1;
    case (off)
      0:  return (m_ie[c] << 8) | (m_en[c] << 5) | (m_os[c] << 4) | m_pre[c];
      4:  return m_st[c];
      8:  return m_rel[c];
      12: return m_cnt[c];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_ie[c] = 0; m_en[c] = 0; m_os[c] = 0; m_pre[c] = 0;
        m_rel[c] = 0; m_cnt[c] = 0; m_div[c] = 0; m_st[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int nen, ncnt, ndiv, nst, bank, off, d;
        bit tick, exp_now;
        nen = m_en[c]; ncnt = m_cnt[c]; ndiv = m_div[c]; nst = m_st[c];
        tick = 0; exp_now = 0;
        if (m_en[c] != 0) begin
          if (m_div[c] == lim_of(c)) begin tick = 1; ndiv = 0; end
          else ndiv = m_div[c] + 1;
        end
        if (tick) begin
          if (m_cnt[c] == m_rel[c]) begin
            exp_now = 1; nst = 1;
            if (m_os[c] != 0) nen = 0; else ncnt = 0;
          end else ncnt = (m_cnt[c] + 1) & 16'hFFFF;
        end
        bank = int'(bus_addr) >> 7;
        off  = int'(bus_addr) & 127;
        d    = int'(bus_wdata);
        if (bus_valid && bus_write && bank == c + 1) begin
          case (off)
            0: begin
              m_ie[c] = (d >> 8) & 1; m_os[c] = (d >> 4) & 1; m_pre[c] = d & 15;
              if (((d >> 5) & 1) != 0 && m_en[c] == 0) begin ncnt = 0; ndiv = 0; end
              nen = (d >> 5) & 1;
            end
            4: if ((d & 1) != 0 && !exp_now) nst = 0;
            8: m_rel[c] = d;
            default: ;
          endcase
        end
        m_en[c] = nen; m_cnt[c] = ncnt; m_div[c] = ndiv; m_st[c] = nst;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R8 / R12: irq of each channel against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++)
        check("R8 irq per cycle", int'(irq[c]), (m_st[c] != 0 && m_ie[c] != 0) ? 1 : 0);
    end
  end

  task automatic drive_now(int a, int d);
    bus_valid = 1; bus_write = 1; bus_addr = 10'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    drive_now(a, d);
  endtask

  task automatic rd(int a, string tag, output int val);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = 10'(a);
    #1;
    val = int'(bus_rdata);
    check(tag, val, model_read(a));
    bus_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, v2, n;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R11: everything zero after reset
    foreach (m_en[c]) begin
      int base;
      base = 'h80 * (c + 1);
      for (int o = 0; o < 16; o += 4) begin
        rd(base + o, "R11 reset read", v);
        check("R11 reset value", v, 0);
      end
    end
    check("R11 irq low", int'(irq), 0);

    // R1: bank placement of reload registers
    wr('h088, 'h005A);
    wr('h108, 'h00A5);
    rd('h088, "R1 ch0 reload", v); check("R1 ch0 reload value", v, 'h5A);
    rd('h108, "R1 ch1 reload", v); check("R1 ch1 reload value", v, 'hA5);

    // R2: control field layout, unused bits read zero
    wr('h080, 'hFFDF);
    rd('h080, "R2 ctrl readback", v); check("R2 ctrl fields", v, 'h011F);
    wr('h080, 0);

    // R4: first expiry after (reload+1)*2 cycles, code 1
    wr('h088, 5);
    wr('h080, 'h121);
    n = 0;
    while (!irq[0] && n < 100) begin @(negedge clk); n++; end
    check("R4 first expiry cycles", n, 12);
    rd('h08C, "R4 count read", v);

    // R7: auto-reload keeps running; clear status and watch the next event
    repeat (30) @(negedge clk);
    rd('h084, "R7 status still set", v); check("R7 status set", v, 1);
    wr('h084, 1);
    rd('h084, "R5 status cleared", v);
    n = 0;
    while (!irq[0] && n < 100) begin @(negedge clk); n++; end
    check("R7 periodic event seen", int'(irq[0]), 1);
    rd('h08C, "R7 count after reload", v);

    // R5: clear landing on the expiry edge, expiry wins
    wr('h080, 'h100);
    wr('h084, 1);
    wr('h088, 4);
    wr('h080, 'h120);
    @(negedge clk);
    while (!will_expire(0)) @(negedge clk);
    drive_now('h084, 1);
    rd('h084, "R5 collision status", v); check("R5 expiry beats clear", v, 1);

    // control write on an expiry edge of a running channel
    while (!will_expire(0)) @(negedge clk);
    drive_now('h080, 'h123);
    rd('h080, "R4 ctrl write at expiry", v);
    rd('h08C, "R4 count after ctrl at expiry", v);

    // R9: stopped channel holds; count writes ignored
    wr('h080, 'h100);
    rd('h08C, "R9 count held a", v);
    repeat (10) @(negedge clk);
    rd('h08C, "R9 count held b", v2); check("R9 count frozen", v2, v);
    wr('h08C, 'h1234);
    rd('h08C, "R9 count write ignored", v2); check("R9 count unchanged", v2, v);
    wr('h084, 1);

    // R6: one-shot, code 2, reload 3
    wr('h088, 3);
    wr('h080, 'h132);
    repeat (40) @(negedge clk);
    rd('h080, "R6 ctrl after one-shot", v); check("R6 enable cleared", v, 'h112);
    rd('h08C, "R6 count held", v); check("R6 count at reload", v, 3);
    check("R6 irq raised", int'(irq[0]), 1);
    wr('h084, 1);

    // R3: code 12 saturates to divide by 256, reload 1 -> 512 cycles
    wr('h108, 1);
    wr('h100, 'h12C);
    n = 0;
    while (!irq[1] && n < 2000) begin @(negedge clk); n++; end
    check("R3 saturated prescale cycles", n, 512);

    // R12: both channels running together
    wr('h088, 2);
    wr('h080, 'h120);
    repeat (600) @(negedge clk);
    rd('h08C, "R12 ch0 count", v);
    rd('h10C, "R12 ch1 count", v);
    rd('h104, "R12 ch1 status", v);

    // R10: unmapped addresses
    rd('h000, "R10 unmapped 0x000", v); check("R10 zero 0x000", v, 0);
    rd('h090, "R10 unmapped 0x090", v); check("R10 zero 0x090", v, 0);
    rd('h180, "R10 unmapped 0x180", v); check("R10 zero 0x180", v, 0);
    rd('h3FC, "R10 unmapped 0x3FC", v); check("R10 zero 0x3FC", v, 0);
    wr('h180, 'hFFFF);
    wr('h094, 1);
    wr('h010, 'hFFFF);
    rd('h080, "R10 ctrl0 untouched", v);
    rd('h100, "R10 ctrl1 untouched", v);
    rd('h088, "R10 reload0 untouched", v);
    @(negedge clk); #1;
    check("R10 idle rdata", int'(bus_rdata), 0);

    // R8: interrupt disabled, status still set
    wr('h100, 'h02C);
    wr('h104, 1);
    n = 0;
    while (m_st[1] == 0 && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    rd('h104, "R8 status without ie", v); check("R8 status set", v, 1);
    check("R8 irq masked", int'(irq[1]), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule